// File: doc/BRIEF.md
# Key-Protected Configuration Register Guard

This block protects a small bank of memory-controller configuration registers on a plain word-addressed bus with single-cycle read and write strobes. Word 0 is a key register. What it holds is not the value last written to it. It holds a lock state that software moves by writing magic values. One value opens the bank for writes. A second value freezes the whole bank until the next reset. Any other value closes the bank again.

Writes that the current lock state does not allow are dropped, and each one raises a one-cycle error pulse. Reads are allowed in every lock state and take one cycle. A parameter selects a legacy variant that has no freeze state. The configuration registers are generic 32-bit words. Each one resets to a value set by parameters.

Top module: `cfg_lock_guard`

## Requirements
- R1: After reset the lock state is soft-locked, so the key register at word 0 reads 0x00000000. Configuration register k, at word k+1, reads CFG_RST_BASE + k.
- R2: Writing 0xFC600309 to word 0 in a state that is not hard-locked selects the unlocked state, and word 0 then reads 0x00000001. While unlocked, writes to words 1..NUM_CFG update the addressed register and raise no error.
- R3: When HARD_LOCK_EN=1, writing 0xDEADDEAD to word 0 in a state that is not hard-locked selects the hard-locked state, and word 0 then reads 0x00000010.
- R4: Writing any other value to word 0 in a state that is not hard-locked selects the soft-locked state, and word 0 then reads 0x00000000.
- R5: While soft-locked, a write to any word other than 0 changes no register and is flagged as an error. A write to word 0 is accepted with no error.
- R6: While hard-locked, every write is dropped and flagged, including writes to word 0 that carry the unlock key. The state is left only by reset.
- R7: When HARD_LOCK_EN=0, 0xDEADDEAD gives the soft-locked state like any other non-unlock value, and the hard-locked state is never entered.
- R8: write_error_o is registered. It is high for exactly the one cycle after each rejected write and low after an accepted write or an idle cycle.
- R9: A read strobe updates rdata_o on the next clock edge in every lock state. Word 0 returns the lock encoding. Words above NUM_CFG return zero. rdata_o holds its value while rd_en_i is low.
- R10: A write to a word above NUM_CFG changes no register. It raises an error only when the bank is not unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| write_error_o | output | 1 | One-cycle pulse for a rejected write |

## Verification
The bench builds two copies of the guard with ADDR_W=3 and NUM_CFG=3. One copy has HARD_LOCK_EN=1 and the other has HARD_LOCK_EN=0, and both are driven from the same bus. The 3-bit address lets every sweep cover the whole space, including four words above the bank. In each of the three lock states the bench writes every word and reads every word back. Because both copies see the same key writes, the legacy mapping of the freeze key is compared directly against the hard-lock behaviour. A reset in the middle of the run shows that only reset releases the freeze.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    LK_SOFT = 2'd0,
    LK_OPEN = 2'd1,
    LK_HARD = 2'd2
  } lock_state_e;

  localparam logic [DATA_W-1:0] KEY_OPEN   = 32'hFC60_0309;
  localparam logic [DATA_W-1:0] KEY_FREEZE = 32'hDEAD_DEAD;

  localparam logic [DATA_W-1:0] RB_SOFT = 32'h0000_0000;
  localparam logic [DATA_W-1:0] RB_OPEN = 32'h0000_0001;
  localparam logic [DATA_W-1:0] RB_HARD = 32'h0000_0010;

  function automatic logic [DATA_W-1:0] lock_readback(lock_state_e s);
    case (s)
      LK_OPEN: return RB_OPEN;
      LK_HARD: return RB_HARD;
      default: return RB_SOFT;
    endcase
  endfunction
endpackage

// File: rtl/cfg_lock_keydec.sv
module cfg_lock_keydec
  import cfg_lock_pkg::*;
#(
  parameter bit HARD_LOCK_EN = 1'b1
) (
  input  logic [DATA_W-1:0] key_i,
  output lock_state_e       state_o
);
  logic hit_open, hit_freeze;

  assign hit_open   = (key_i == KEY_OPEN);
  assign hit_freeze = (key_i == KEY_FREEZE);

  generate
    if (HARD_LOCK_EN) begin : g_hard
      always_comb begin
        if (hit_open)        state_o = LK_OPEN;
        else if (hit_freeze) state_o = LK_HARD;
        else                 state_o = LK_SOFT;
      end
    end else begin : g_legacy
      always_comb begin
        state_o = hit_open ? LK_OPEN : LK_SOFT;
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
  import cfg_lock_pkg::*;
#(
  parameter bit HARD_LOCK_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_wr_i,
  input  lock_state_e key_state_i,
  output lock_state_e state_o
);
  lock_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            state_q <= LK_SOFT;
    else if (key_wr_i && state_q != LK_HARD) state_q <= key_state_i;
  end

  assign state_o = state_q;

  AST_HARD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == LK_HARD |=> state_q == LK_HARD); // R6

  AST_KEY_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && state_q != LK_HARD) |=> state_q == $past(key_state_i)); // R4

  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {LK_SOFT, LK_OPEN, LK_HARD}); // R1

  generate
    if (!HARD_LOCK_EN) begin : g_no_hard
      AST_LEGACY_NO_HARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_wr_i |=> state_q != LK_HARD); // R7
    end
  endgenerate
endmodule

// File: rtl/cfg_lock_regbank.sv
module cfg_lock_regbank
  import cfg_lock_pkg::*;
#(
  parameter int unsigned     NUM_CFG      = 4,
  parameter logic [DATA_W-1:0] CFG_RST_BASE = 32'h0000_0000
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CFG-1:0]             wr_sel_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_CFG-1:0][DATA_W-1:0] cfg_o
);
  generate
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_reg
      localparam logic [DATA_W-1:0] RST_VAL = CFG_RST_BASE + DATA_W'(i);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          q <= RST_VAL;
        else if (wr_sel_i[i]) q <= wdata_i;
      end
      assign cfg_o[i] = q;
    end
  endgenerate

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_i)); // R2
endmodule

// File: rtl/cfg_lock_guard.sv
module cfg_lock_guard
  import cfg_lock_pkg::*;
#(
  parameter int unsigned       ADDR_W       = 4,
  parameter int unsigned       NUM_CFG      = 4,
  parameter bit                HARD_LOCK_EN = 1'b1,
  parameter logic [31:0]       CFG_RST_BASE = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              write_error_o
);
  localparam logic [ADDR_W-1:0] KEY_ADDR = '0;

  lock_state_e state, key_state;
  logic [NUM_CFG-1:0]             addr_hit, wr_sel;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg;
  logic is_key, reject, key_wr;
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic err_q;

  assign is_key = (addr_i == KEY_ADDR);

  generate
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_dec
      assign addr_hit[i] = (addr_i == ADDR_W'(i + 1));
      assign wr_sel[i]   = wr_en_i && addr_hit[i] && (state == LK_OPEN);
    end
  endgenerate

  // hard lock blocks all; soft lock blocks all but the key word
  assign reject = wr_en_i && ((state == LK_HARD) || (state == LK_SOFT && !is_key));
  assign key_wr = wr_en_i && is_key;

  cfg_lock_keydec #(.HARD_LOCK_EN(HARD_LOCK_EN)) u_keydec (
    .key_i   (wdata_i),
    .state_o (key_state)
  );

  cfg_lock_fsm #(.HARD_LOCK_EN(HARD_LOCK_EN)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_wr_i    (key_wr),
    .key_state_i (key_state),
    .state_o     (state)
  );

  cfg_lock_regbank #(.NUM_CFG(NUM_CFG), .CFG_RST_BASE(CFG_RST_BASE)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_sel),
    .wdata_i  (wdata_i),
    .cfg_o    (cfg)
  );

  always_comb begin
    rd_val = '0;
    if (is_key) rd_val = lock_readback(state);
    for (int i = 0; i < NUM_CFG; i++) begin
      if (addr_hit[i]) rd_val = cfg[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_q <= rd_val;
      err_q <= reject;
    end
  end

  assign rdata_o       = rdata_q;
  assign write_error_o = err_q;

  AST_REJECT_HOLDS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> $stable(cfg)); // R5

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_error_o |-> $past(wr_en_i)); // R8

  AST_OPEN_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state == LK_OPEN) |=> !write_error_o); // R2

  AST_UNLOCK_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wdata_i == KEY_OPEN && state != LK_HARD) |=> state == LK_OPEN); // R2

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R9

  AST_HARD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state == LK_HARD) |=> write_error_o); // R6
endmodule

// File: tb/cfg_lock_guard_tb_top.sv
module cfg_lock_guard_tb_top;
  import cfg_lock_pkg::*;

  localparam int AW = 3;
  localparam int NC = 3;
  localparam int NADDR = 1 << AW;
  localparam logic [31:0] BASE = 32'hC0DE_0100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_h, rdata_l;
  logic err_h, err_l;

  cfg_lock_guard #(.ADDR_W(AW), .NUM_CFG(NC), .HARD_LOCK_EN(1'b1), .CFG_RST_BASE(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_h), .write_error_o(err_h));

  cfg_lock_guard #(.ADDR_W(AW), .NUM_CFG(NC), .HARD_LOCK_EN(1'b0), .CFG_RST_BASE(BASE)) dut_legacy_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_l), .write_error_o(err_l));

  int checks = 0, errors = 0;
  bit reported = 1'b0;
  int lk [2];            // 0 soft, 1 open, 2 hard
  logic [31:0] cfg_m [2][NC];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  function automatic void model_reset();
    for (int w = 0; w < 2; w++) begin
      lk[w] = 0;
      for (int i = 0; i < NC; i++) cfg_m[w][i] = BASE + 32'(i);
    end
  endfunction

  function automatic logic model_wr(int w, int a, logic [31:0] d);
    logic rej;
    rej = (lk[w] == 2) || (lk[w] == 0 && a != 0);
    if (!rej) begin
      if (a == 0) begin
        if (d == 32'hFC60_0309) lk[w] = 1;
        else if (d == 32'hDEAD_DEAD && w == 0) lk[w] = 2;
        else lk[w] = 0;
      end else if (a <= NC) begin
        cfg_m[w][a-1] = d;
      end
    end
    return rej;
  endfunction

  function automatic logic [31:0] model_rd(int w, int a);
    if (a == 0) return (lk[w] == 1) ? 32'h1 : (lk[w] == 2) ? 32'h10 : 32'h0;
    if (a <= NC) return cfg_m[w][a-1];
    return 32'h0;
  endfunction

  task automatic wr(int a, logic [31:0] d, string req);
    logic eh, el;
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    eh = model_wr(0, a, d);
    el = model_wr(1, a, d);
    chk({req, " err"}, 32'(err_h), 32'(eh));
    chk({req, " err legacy"}, 32'(err_l), 32'(el));
  endtask

  task automatic rd(int a, string req);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk({req, " R9 rdata"}, rdata_h, model_rd(0, a));
    chk({req, " R9 rdata legacy"}, rdata_l, model_rd(1, a));
    chk("R8 idle err", 32'({err_h, err_l}), 32'h0);
  endtask

  task automatic rd_all(string req);
    for (int a = 0; a < NADDR; a++) rd(a, req);
    @(negedge clk);
    chk("R9 hold", rdata_h, model_rd(0, NADDR - 1));
  endtask

  task automatic sweep(string req);
    for (int a = 1; a < NADDR; a++)
      wr(a, {8'(a), 8'hA5, 8'(checks), 8'h3C}, (a > NC) ? "R10" : req);
    rd_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_all("R1");
    sweep("R5");
    wr(0, 32'h1234_5678, "R4"); rd(0, "R4");
    wr(0, 32'hFC60_0309, "R2"); rd(0, "R2");
    sweep("R2");
    wr(0, 32'hFC60_0308, "R4"); rd(0, "R4");
    sweep("R5");
    wr(0, 32'hFC60_0309, "R2");
    wr(0, 32'hDEAD_DEAD, "R3 R7"); rd(0, "R3 R7");
    sweep("R6");
    wr(0, 32'hFC60_0309, "R6"); rd(0, "R6");
    wr(0, 32'h0000_0000, "R6"); rd(0, "R6");
    sweep("R6");
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_all("R1 R6");
    wr(0, 32'hFC60_0309, "R2");
    sweep("R2");
    report();
    $finish;
  end
endmodule